// File: doc/BRIEF.md
# Powerline Command Frame Decoder

This block sits behind a bit sampler in a powerline home-control receiver. Each time the sampler produces a new bit it presents the last 22 received bits as a window and pulses a strobe. On every strobe the decoder checks whether the window holds one whole command frame, decides whether the frame is meant for this receiver, and updates the lamp state or asks an external dimmer for one step brighter or dimmer.

A frame is a four-bit start marker followed by nine data bits. Each data bit is sent as a pair: the bit and then its complement. The first four data bits carry the house address and the last five carry the key. The last key bit separates unit-address frames from function frames. Two four-bit switch inputs pick this receiver's house letter and unit number. Both go through the same fixed sixteen-entry letter table before they are compared. Because a fresh window is checked on every bit, a valid frame is still found when it arrives right after a broken one.

Top module: `plcmd_decoder`

## Requirements
- R1: After reset, lampOn is 1, brightPulse and dimPulse are 0, and the receiver is not addressed.
- R2: A window is used only when its oldest four bits, histWord[21:18], read 1,1,1,0 from bit 21 down to bit 18. Any other marker leaves every output unchanged.
- R3: The 18 bits below the marker form nine pairs, pair k being histWord[17-2k] and histWord[16-2k]. If any pair holds two equal bits, the whole window has no effect.
- R4: Data bit k is histWord[17-2k], so pair 10 means 1 and pair 01 means 0. The house code is data bits 0..3, with bit 0 as the MSB. A switch value s maps to a code by this table, index 0 to 15: 0110, 1110, 0010, 1010, 0001, 1001, 0101, 1101, 0111, 1111, 0011, 1011, 0000, 1000, 0100, 1100. A frame whose house code is not the mapped houseSel value has no effect.
- R5: The key is data bits 4..8, with bit 4 as the MSB. When key bit 8 is 0, the frame is a unit address. It sets the addressed flag if data bits 4..7 equal the mapped unitSel value, and clears the flag otherwise.
- R6: When key bit 8 is 1, data bits 4..7 form the function code. Codes 0000 (all units off) and 0110 (all lights off) drive lampOn to 0, and 0001 (all lights on) drives it to 1. These three codes act whether or not the receiver is addressed.
- R7: Function 0010 (on) sets lampOn and 0011 (off) clears it, but only while the receiver is addressed. Neither command changes the addressed flag.
- R8: Function 0100 (dim) gives a one-clock dimPulse and 0101 (bright) gives a one-clock brightPulse, only while the receiver is addressed. Each frame yields at most one pulse, and the two pulses never occur together.
- R9: Function codes 0111 and 1000 to 1111 change nothing.
- R10: Outputs change only in the clock cycle after a strobe. Without histValid, a changing histWord has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| histWord | input | 22 | Received bit window, bit 21 oldest |
| histValid | input | 1 | One-cycle strobe: a new bit has entered the window |
| houseSel | input | 4 | House letter switch (index into the letter table) |
| unitSel | input | 4 | Unit number switch (index into the letter table) |
| lampOn | output | 1 | Lamp state |
| brightPulse | output | 1 | One-cycle request for one brightness step up |
| dimPulse | output | 1 | One-cycle request for one brightness step down |

## Verification
The bench goes after windows that differ from a good frame in a single place. These are a broken marker, one equal pair at either end of the data field, and a house code from the neighbouring table entry. A decoder that skipped any of these gates would change the lamp on a frame meant for nobody. It also tests that on, off, bright and dim are refused after a unit address for another receiver, but still work after a matching address followed by an on command. A design that reset or ignored the addressed flag would fail this in opposite ways. Sweeping every switch value for both house and unit catches a wrong or mirrored table entry. Driving the window without a strobe, and checking that each pulse drops after one cycle, catches logic that decodes all the time or holds its pulses.

// File: rtl/plcmd_pkg.sv
`timescale 1ns/1ps
package plcmd_pkg;

  // Function codes carried in the four command bits of a function frame
  localparam logic [3:0] FN_ALL_UNITS_OFF  = 4'b0000;
  localparam logic [3:0] FN_ALL_LIGHTS_ON  = 4'b0001;
  localparam logic [3:0] FN_ON             = 4'b0010;
  localparam logic [3:0] FN_OFF            = 4'b0011;
  localparam logic [3:0] FN_DIM            = 4'b0100;
  localparam logic [3:0] FN_BRIGHT         = 4'b0101;
  localparam logic [3:0] FN_ALL_LIGHTS_OFF = 4'b0110;

  // Strobes from the control decision to the state datapath
  typedef struct packed {
    logic addrSet;
    logic addrClr;
    logic lampSet;
    logic lampClr;
    logic brightStb;
    logic dimStb;
  } ctrlStb_t;

  // Switch index to over-the-line letter/unit code
  function automatic logic [3:0] letterCode(input logic [3:0] idx);
    logic [3:0] code;
    case (idx)
      4'd0:  code = 4'b0110;
      4'd1:  code = 4'b1110;
      4'd2:  code = 4'b0010;
      4'd3:  code = 4'b1010;
      4'd4:  code = 4'b0001;
      4'd5:  code = 4'b1001;
      4'd6:  code = 4'b0101;
      4'd7:  code = 4'b1101;
      4'd8:  code = 4'b0111;
      4'd9:  code = 4'b1111;
      4'd10: code = 4'b0011;
      4'd11: code = 4'b1011;
      4'd12: code = 4'b0000;
      4'd13: code = 4'b1000;
      4'd14: code = 4'b0100;
      default: code = 4'b1100;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/plcmd_parse.sv
`timescale 1ns/1ps
module plcmd_parse #(
  parameter int WIN_W     = 22,
  parameter int START_W   = 4,
  parameter int DATA_BITS = 9,
  parameter int HOUSE_W   = 4,
  parameter logic [START_W-1:0] START_CODE = 4'b1110,
  localparam int KEY_W    = DATA_BITS - HOUSE_W
) (
  input  logic [WIN_W-1:0]   histWord,
  output logic               frameOk,
  output logic [HOUSE_W-1:0] houseRx,
  output logic [KEY_W-1:0]   keyRx
);
  localparam int PAIR_W = WIN_W - START_W;

  logic [DATA_BITS-1:0] dataBits;
  logic [DATA_BITS-1:0] pairOk;
  logic                 startOk;

  // Pair k occupies the two bits just below pair k-1, newest pairs at the bottom
  for (genvar k = 0; k < DATA_BITS; k++) begin : g_pair
    assign dataBits[DATA_BITS-1-k] = histWord[PAIR_W-1-2*k];
    assign pairOk[k] = histWord[PAIR_W-1-2*k] ^ histWord[PAIR_W-2-2*k];
  end

  assign startOk = (histWord[WIN_W-1 -: START_W] == START_CODE);
  assign frameOk = startOk & (&pairOk);
  assign houseRx = dataBits[DATA_BITS-1 -: HOUSE_W];
  assign keyRx   = dataBits[KEY_W-1:0];

  initial begin
    assert (PAIR_W == 2 * DATA_BITS)
      else $error("window width does not match the pair count");
  end
endmodule

// File: rtl/plcmd_ctrl.sv
`timescale 1ns/1ps
module plcmd_ctrl
  import plcmd_pkg::*;
#(
  parameter int HOUSE_W = 4,
  parameter int KEY_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobeIn,
  input  logic               frameOk,
  input  logic [HOUSE_W-1:0] houseRx,
  input  logic [KEY_W-1:0]   keyRx,
  input  logic [3:0]         houseSel,
  input  logic [3:0]         unitSel,
  input  logic               addressed,
  output ctrlStb_t           stb
);
  logic       houseHit;
  logic       accept;
  logic       isFunc;
  logic [3:0] cmd;

  assign houseHit = (houseRx == letterCode(houseSel));
  assign accept   = strobeIn & frameOk & houseHit;
  assign isFunc   = keyRx[0];
  assign cmd      = keyRx[KEY_W-1 -: 4];

  always_comb begin
    stb = '0;
    if (accept) begin
      if (!isFunc) begin
        if (cmd == letterCode(unitSel)) stb.addrSet = 1'b1;
        else                            stb.addrClr = 1'b1;
      end else begin
        case (cmd)
          FN_ALL_UNITS_OFF,
          FN_ALL_LIGHTS_OFF: stb.lampClr = 1'b1;
          FN_ALL_LIGHTS_ON:  stb.lampSet = 1'b1;
          FN_ON:             stb.lampSet = addressed;
          FN_OFF:            stb.lampClr = addressed;
          FN_DIM:            stb.dimStb  = addressed;
          FN_BRIGHT:         stb.brightStb = addressed;
          default:           stb = '0;
        endcase
      end
    end
  end

  // R8: one decision per frame, never two actions at once
  p_single_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R3: no action unless the parser reported a well-formed window on a strobe
  p_needs_good_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |-> (strobeIn && frameOk));

  // R4: no action unless the received house matches the mapped switch
  p_house_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |-> (houseRx == letterCode(houseSel)));
endmodule

// File: rtl/plcmd_regs.sv
`timescale 1ns/1ps
module plcmd_regs
  import plcmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobeIn,
  input  ctrlStb_t stb,
  output logic     addressed,
  output logic     lampOn,
  output logic     brightPulse,
  output logic     dimPulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed   <= 1'b0;
      lampOn      <= 1'b1;
      brightPulse <= 1'b0;
      dimPulse    <= 1'b0;
    end else begin
      if (stb.addrSet)      addressed <= 1'b1;
      else if (stb.addrClr) addressed <= 1'b0;
      if (stb.lampSet)      lampOn <= 1'b1;
      else if (stb.lampClr) lampOn <= 1'b0;
      brightPulse <= stb.brightStb;
      dimPulse    <= stb.dimStb;
    end
  end

  // R8: the two dimmer requests never coincide
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(brightPulse && dimPulse));

  // R8: a pulse without a fresh strobe lasts one cycle
  p_bright_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brightPulse && !strobeIn) |=> !brightPulse);
  p_dim_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dimPulse && !strobeIn) |=> !dimPulse);

  // R8: a pulse is only ever issued while addressed
  p_pulse_addressed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brightPulse || dimPulse) |-> addressed);

  // R10: without a strobe, state holds and no pulse follows
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobeIn |=> ($stable(lampOn) && $stable(addressed) && !brightPulse && !dimPulse));
endmodule

// File: rtl/plcmd_decoder.sv
`timescale 1ns/1ps
module plcmd_decoder
  import plcmd_pkg::*;
#(
  parameter int WIN_W     = 22,
  parameter int START_W   = 4,
  parameter int DATA_BITS = 9,
  parameter int HOUSE_W   = 4,
  localparam int KEY_W    = DATA_BITS - HOUSE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] histWord,
  input  logic             histValid,
  input  logic [3:0]       houseSel,
  input  logic [3:0]       unitSel,
  output logic             lampOn,
  output logic             brightPulse,
  output logic             dimPulse
);
  logic               frameOk;
  logic [HOUSE_W-1:0] houseRx;
  logic [KEY_W-1:0]   keyRx;
  logic               addressed;
  ctrlStb_t           stb;

  plcmd_parse #(
    .WIN_W(WIN_W), .START_W(START_W), .DATA_BITS(DATA_BITS), .HOUSE_W(HOUSE_W)
  ) u_parse (
    .histWord(histWord), .frameOk(frameOk), .houseRx(houseRx), .keyRx(keyRx)
  );

  plcmd_ctrl #(.HOUSE_W(HOUSE_W), .KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobeIn(histValid), .frameOk(frameOk),
    .houseRx(houseRx), .keyRx(keyRx), .houseSel(houseSel), .unitSel(unitSel),
    .addressed(addressed), .stb(stb)
  );

  plcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strobeIn(histValid), .stb(stb),
    .addressed(addressed), .lampOn(lampOn),
    .brightPulse(brightPulse), .dimPulse(dimPulse)
  );
endmodule

// File: tb/plcmd_decoder_bench.sv
`timescale 1ns/1ps
module plcmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] histWord = '0;
  logic        histValid = 1'b0;
  logic [3:0]  houseSel = 4'd0;
  logic [3:0]  unitSel = 4'd3;
  logic        lampOn, brightPulse, dimPulse;

  int nChecks = 0;
  int nFails  = 0;
  string curTag = "R10";

  int tbl [16];
  // model state
  int mLamp = 1, mAddr = 0, mBr = 0, mDm = 0;

  always #4 clk = ~clk;

  plcmd_decoder u_plcmd_decoder (
    .clk(clk), .rst_n(rst_n), .histWord(histWord), .histValid(histValid),
    .houseSel(houseSel), .unitSel(unitSel),
    .lampOn(lampOn), .brightPulse(brightPulse), .dimPulse(dimPulse)
  );

  // Behavioural reference, stepped on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      mLamp = 1; mAddr = 0; mBr = 0; mDm = 0;
    end else begin
      int ok, d, hs, ky, op;
      mBr = 0; mDm = 0;
      if (histValid) begin
        ok = (histWord[21:18] == 4'b1110) ? 1 : 0;
        d = 0;
        for (int i = 0; i < 9; i++) begin
          if (histWord[17-2*i] == histWord[16-2*i]) ok = 0;
          d = d * 2 + int'(histWord[17-2*i]);
        end
        hs = d / 32;
        ky = d % 32;
        op = ky / 2;
        if (ok == 1 && hs == tbl[houseSel]) begin
          if (ky % 2 == 0) mAddr = (op == tbl[unitSel]) ? 1 : 0;
          else begin
            if (op == 0 || op == 6) mLamp = 0;
            else if (op == 1) mLamp = 1;
            else if (op == 2 && mAddr == 1) mLamp = 1;
            else if (op == 3 && mAddr == 1) mLamp = 0;
            else if (op == 4 && mAddr == 1) mDm = 1;
            else if (op == 5 && mAddr == 1) mBr = 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(lampOn == mLamp[0], curTag, "model lampOn", lampOn, mLamp);
      chk(brightPulse == mBr[0], curTag, "model brightPulse", brightPulse, mBr);
      chk(dimPulse == mDm[0], curTag, "model dimPulse", dimPulse, mDm);
    end
  end

  function automatic logic [21:0] mk(input logic [3:0] h, input logic [4:0] k);
    logic [21:0] w;
    logic [8:0] d;
    d = {h, k};
    w = 22'(4'b1110);
    for (int i = 8; i >= 0; i--) w = {w[19:0], d[i], ~d[i]};
    return w;
  endfunction

  // Strobe one window; returns at the negedge where the result is visible
  task automatic send(input logic [21:0] w, input string tag);
    curTag = tag;
    @(negedge clk);
    histWord = w;
    histValid = 1'b1;
    @(negedge clk);
    histValid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    tbl = '{6, 14, 2, 10, 1, 9, 5, 13, 7, 15, 3, 11, 0, 8, 4, 12};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lampOn == 1'b1, "R1", "lampOn after reset", lampOn, 1);
    chk(brightPulse == 1'b0 && dimPulse == 1'b0, "R1", "pulses after reset",
        int'(brightPulse) + int'(dimPulse), 0);
    // R1: not addressed -> dim refused
    send(mk(4'b0110, 5'b01001), "R1");
    chk(dimPulse == 1'b0, "R1", "dim while unaddressed after reset", dimPulse, 0);

    // R6 all units off / all lights on, no address needed
    send(mk(4'b0110, 5'b00001), "R6");
    chk(lampOn == 1'b0, "R6", "all units off", lampOn, 0);
    send(mk(4'b0110, 5'b00011), "R6");
    chk(lampOn == 1'b1, "R6", "all lights on", lampOn, 1);
    send(mk(4'b0110, 5'b01101), "R6");
    chk(lampOn == 1'b0, "R6", "all lights off", lampOn, 0);

    // R7 on refused while unaddressed
    send(mk(4'b0110, 5'b00101), "R7");
    chk(lampOn == 1'b0, "R7", "on while unaddressed", lampOn, 0);

    // R5 address unit 3 (code 1010), then on/dim/bright apply
    send(mk(4'b0110, 5'b10100), "R5");
    send(mk(4'b0110, 5'b00101), "R7");
    chk(lampOn == 1'b1, "R7", "on after matching address", lampOn, 1);
    send(mk(4'b0110, 5'b01001), "R8");
    chk(dimPulse == 1'b1 && brightPulse == 1'b0, "R8", "dim pulse", dimPulse, 1);
    @(negedge clk);
    chk(dimPulse == 1'b0, "R8", "dim pulse one cycle", dimPulse, 0);
    send(mk(4'b0110, 5'b01011), "R8");
    chk(brightPulse == 1'b1 && dimPulse == 1'b0, "R8", "bright pulse after on", brightPulse, 1);
    @(negedge clk);
    chk(brightPulse == 1'b0, "R8", "bright pulse one cycle", brightPulse, 0);

    // R4 wrong house letter ignored
    send(mk(4'b1110, 5'b00001), "R4");
    chk(lampOn == 1'b1, "R4", "neighbour house ignored", lampOn, 1);
    // R3 broken pair at first and last position
    send(mk(4'b0110, 5'b00001) ^ 22'h010000, "R3");
    chk(lampOn == 1'b1, "R3", "first pair equal", lampOn, 1);
    send(mk(4'b0110, 5'b00001) ^ 22'h000001, "R3");
    chk(lampOn == 1'b1, "R3", "last pair equal", lampOn, 1);
    // R2 bad marker
    send(mk(4'b0110, 5'b00001) ^ 22'h080000, "R2");
    chk(lampOn == 1'b1, "R2", "marker 1100 ignored", lampOn, 1);
    send(mk(4'b0110, 5'b00001) ^ 22'h040000, "R2");
    chk(lampOn == 1'b1, "R2", "marker 1111 ignored", lampOn, 1);

    // R9 reserved codes ignored
    send(mk(4'b0110, 5'b10001), "R9");
    chk(lampOn == 1'b1, "R9", "code 1000 ignored", lampOn, 1);
    send(mk(4'b0110, 5'b01111), "R9");
    chk(lampOn == 1'b1, "R9", "code 0111 ignored", lampOn, 1);
    send(mk(4'b0110, 5'b10111), "R9");
    chk(lampOn == 1'b1, "R9", "code 1011 ignored", lampOn, 1);

    // R5 other unit clears the flag; off and bright refused
    send(mk(4'b0110, 5'b01100), "R5");
    send(mk(4'b0110, 5'b00111), "R7");
    chk(lampOn == 1'b1, "R7", "off after foreign address", lampOn, 1);
    send(mk(4'b0110, 5'b01011), "R8");
    chk(brightPulse == 1'b0, "R8", "bright after foreign address", brightPulse, 0);

    // R10 window moves without strobe
    curTag = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      histWord = mk(4'b0110, 5'b00001) ^ 22'(i);
    end
    @(negedge clk);
    chk(lampOn == 1'b1, "R10", "no strobe no change", lampOn, 1);

    // R4 sweep house switch
    for (int s = 0; s < 16; s++) begin
      houseSel = 4'(s);
      send(mk(4'(tbl[s]), 5'b00001), "R4");
      chk(lampOn == 1'b0, "R4", "house sweep off", lampOn, 0);
      send(mk(4'(tbl[(s + 1) % 16]), 5'b00011), "R4");
      chk(lampOn == 1'b0, "R4", "house sweep mismatch", lampOn, 0);
      send(mk(4'(tbl[s]), 5'b00011), "R4");
      chk(lampOn == 1'b1, "R4", "house sweep on", lampOn, 1);
    end

    // R5 sweep unit switch
    houseSel = 4'd5;
    for (int u = 0; u < 16; u++) begin
      unitSel = 4'(u);
      send(mk(4'b1001, 5'b00001), "R6");
      send(mk(4'b1001, {4'(tbl[(u + 3) % 16]), 1'b0}), "R5");
      send(mk(4'b1001, 5'b00101), "R5");
      chk(lampOn == 1'b0, "R5", "unit sweep foreign", lampOn, 0);
      send(mk(4'b1001, {4'(tbl[u]), 1'b0}), "R5");
      send(mk(4'b1001, 5'b00101), "R5");
      chk(lampOn == 1'b1, "R5", "unit sweep match", lampOn, 1);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule